// File: doc/BRIEF.md
# MMD Indirect Access Bridge

This block sits on the PHY side of a Clause 22 management port. It lets that port reach the Clause 45 register space of the PHY's internal MMD devices. Two window registers in the Clause 22 map do the work. The first is a control word that names the target device and picks a function. The second is a window word. Depending on the function, it either sets the register address inside that device or carries data to and from it.

The block keeps one latched register address for each MMD device. It turns every data access through the window into a single-cycle request on a simple internal register port. That request carries the device number, the latched register address, a write flag and the write data. In data mode, the read data of the port is returned on the management read bus in the same cycle.

Two functions advance the latched address by one after an access. One advances it after both reads and writes. The other advances it after writes only. A sequence of window accesses can therefore walk a block of MMD registers without setting the address again.

Top module: `mmd_window_bridge`

## Requirements
- R1: A write to management register 13 stores all 16 bits as the control word. A read of register 13 returns the last value stored. Reads of register 13 have no side effects.
- R2: Bits [4:0] of the control word select the target device. The device select is driven on `mmdDevad`, and that device's latched address is driven on `mmdRegAddr`.
- R3: The control word bits [15:14] select the function. When they are 00 (address function), a write to register 14 loads the selected device's latched address, and a read of register 14 returns that latched address. Neither access raises `mmdStrobe`.
- R4: Any function other than 00 is a data function. In a data function, each access to register 14 raises `mmdStrobe` for exactly that cycle. A read returns `mmdRdata` on `c22Rdata` in the same cycle. With function 01, the latched address stays unchanged.
- R5: With function 10, the selected device's latched address increases by one after every access to register 14, whether it is a read or a write.
- R6: With function 11, the latched address increases by one after a write to register 14. A read of register 14 leaves it unchanged.
- R7: An increment from 0xFFFF gives 0x0000.
- R8: Each of the 32 devices keeps its own latched address. Loading or incrementing one device's address leaves every other device's address unchanged.
- R9: After reset, the control word is 0x0000, which is the address function with device 0. Every latched address is 0x0000.
- R10: An access to any register number other than 13 or 14 changes no state and raises no strobe. A read of such a register returns 0x0000.
- R11: On a data write, `mmdWrite` is high together with `mmdStrobe`, and `mmdWdata` equals the management write data. On a data read, `mmdWrite` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| c22Valid | input | 1 | One management register access in this cycle |
| c22Write | input | 1 | 1 = write access, 0 = read access |
| c22Reg | input | 5 | Management register number |
| c22Wdata | input | 16 | Management write data |
| c22Rdata | output | 16 | Management read data, valid in the access cycle |
| mmdStrobe | output | 1 | MMD register port request |
| mmdWrite | output | 1 | MMD request is a write |
| mmdDevad | output | 5 | MMD device number |
| mmdRegAddr | output | 16 | MMD register address |
| mmdWdata | output | 16 | MMD write data |
| mmdRdata | input | 16 | MMD read data, returned combinationally |

## Verification
Several properties are checked on every cycle:
- A strobe to the MMD port appears only for a window access in a data function, and a write flag never appears without a strobe.
- The control word takes the written value one cycle after a write to it.
- The register address on the port advances by one, or holds, after each strobe, as functions 01, 10 and 11 require.

Other behaviour can only be shown by the bench's scenarios:
- Readback of the control word and of a latched address.
- The values after reset.
- Independence of the per-device addresses.
- Wrap-around at 0xFFFF.
- Silence of accesses to other register numbers.

The bench shows these by comparing each access with its own behavioural model.

// File: rtl/mmd_bridge_pkg.sv
package mmd_bridge_pkg;

  // Function selected by the two top bits of the control word
  typedef enum logic [1:0] {
    FN_ADDR   = 2'b00,
    FN_DATA   = 2'b01,
    FN_INC_RW = 2'b10,
    FN_INC_WR = 2'b11
  } winFunc_e;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic ldCtrl;   // load control word
    logic ldAddr;   // load latched address of selected device
    logic dataAcc;  // data access to the MMD port
    logic dataWr;   // that data access is a write
    logic incAddr;  // post-increment latched address
    logic selCtrl;  // read mux: control word
    logic selAddr;  // read mux: latched address
    logic selData;  // read mux: MMD read data
  } winStrobe_t;

endpackage

// File: rtl/mmd_win_ctrl.sv
module mmd_win_ctrl
  import mmd_bridge_pkg::*;
#(
  parameter int REG_W    = 5,
  parameter int CTRL_REG = 13,
  parameter int DATA_REG = 14
) (
  input  logic             c22Valid,
  input  logic             c22Write,
  input  logic [REG_W-1:0] c22Reg,
  input  winFunc_e         func,
  output winStrobe_t       st
);

  localparam logic [REG_W-1:0] CTRL_IDX = REG_W'(CTRL_REG);
  localparam logic [REG_W-1:0] DATA_IDX = REG_W'(DATA_REG);

  logic hitCtrl;
  logic hitData;
  logic dataMode;

  always_comb begin
    hitCtrl  = c22Valid && (c22Reg == CTRL_IDX);
    hitData  = c22Valid && (c22Reg == DATA_IDX);
    dataMode = (func != FN_ADDR);

    st.ldCtrl  = hitCtrl && c22Write;
    st.ldAddr  = hitData && c22Write && !dataMode;
    st.dataAcc = hitData && dataMode;
    st.dataWr  = hitData && dataMode && c22Write;

    unique case (func)
      FN_INC_RW: st.incAddr = hitData;
      FN_INC_WR: st.incAddr = hitData && c22Write;
      default:   st.incAddr = 1'b0;
    endcase

    st.selCtrl = hitCtrl && !c22Write;
    st.selAddr = hitData && !c22Write && !dataMode;
    st.selData = hitData && !c22Write && dataMode;
  end

endmodule

// File: rtl/mmd_win_datapath.sv
module mmd_win_datapath
  import mmd_bridge_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEV_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  winStrobe_t        st,
  input  logic [DATA_W-1:0] c22Wdata,
  input  logic [DATA_W-1:0] mmdRdata,
  output winFunc_e          func,
  output logic [DATA_W-1:0] ctrlWord,
  output logic [DEV_W-1:0]  mmdDevad,
  output logic [DATA_W-1:0] mmdRegAddr,
  output logic [DATA_W-1:0] mmdWdata,
  output logic [DATA_W-1:0] c22Rdata
);

  localparam int NUM_DEV = 1 << DEV_W;
  localparam int FN_MSB  = DATA_W - 1;

  logic [DATA_W-1:0]               ctrlQ;
  logic [DEV_W-1:0]                devSel;
  logic [NUM_DEV-1:0][DATA_W-1:0]  addrVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ <= '0;
    end else if (st.ldCtrl) begin
      ctrlQ <= c22Wdata;
    end
  end

  assign devSel   = ctrlQ[DEV_W-1:0];
  assign func     = winFunc_e'(ctrlQ[FN_MSB -: 2]);
  assign ctrlWord = ctrlQ;

  // One latched register address per device
  for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
    logic addrReg_sel;
    logic [DATA_W-1:0] addrReg;

    assign addrReg_sel = (devSel == DEV_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        addrReg <= '0;
      end else if (addrReg_sel && st.ldAddr) begin
        addrReg <= c22Wdata;
      end else if (addrReg_sel && st.incAddr) begin
        addrReg <= addrReg + DATA_W'(1);
      end
    end

    assign addrVec[g] = addrReg;
  end

  assign mmdDevad   = devSel;
  assign mmdRegAddr = addrVec[devSel];
  assign mmdWdata   = c22Wdata;

  always_comb begin
    if (st.selCtrl) begin
      c22Rdata = ctrlQ;
    end else if (st.selAddr) begin
      c22Rdata = addrVec[devSel];
    end else if (st.selData) begin
      c22Rdata = mmdRdata;
    end else begin
      c22Rdata = '0;
    end
  end

endmodule

// File: rtl/mmd_window_bridge.sv
module mmd_window_bridge
  import mmd_bridge_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int DEV_W    = 5,
  parameter int REG_W    = 5,
  parameter int CTRL_REG = 13,
  parameter int DATA_REG = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              c22Valid,
  input  logic              c22Write,
  input  logic [REG_W-1:0]  c22Reg,
  input  logic [DATA_W-1:0] c22Wdata,
  output logic [DATA_W-1:0] c22Rdata,
  output logic              mmdStrobe,
  output logic              mmdWrite,
  output logic [DEV_W-1:0]  mmdDevad,
  output logic [DATA_W-1:0] mmdRegAddr,
  output logic [DATA_W-1:0] mmdWdata,
  input  logic [DATA_W-1:0] mmdRdata
);

  winStrobe_t        st;
  winFunc_e          func;
  logic [DATA_W-1:0] ctrlWord;

  mmd_win_ctrl #(
    .REG_W(REG_W), .CTRL_REG(CTRL_REG), .DATA_REG(DATA_REG)
  ) u_ctrl (
    .c22Valid(c22Valid),
    .c22Write(c22Write),
    .c22Reg  (c22Reg),
    .func    (func),
    .st      (st)
  );

  mmd_win_datapath #(
    .DATA_W(DATA_W), .DEV_W(DEV_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .st        (st),
    .c22Wdata  (c22Wdata),
    .mmdRdata  (mmdRdata),
    .func      (func),
    .ctrlWord  (ctrlWord),
    .mmdDevad  (mmdDevad),
    .mmdRegAddr(mmdRegAddr),
    .mmdWdata  (mmdWdata),
    .c22Rdata  (c22Rdata)
  );

  assign mmdStrobe = st.dataAcc;
  assign mmdWrite  = st.dataWr;

endmodule

// File: rtl/mmd_window_bridge_chk.sv
module mmd_window_bridge_chk #(
  parameter int DATA_W   = 16,
  parameter int DEV_W    = 5,
  parameter int REG_W    = 5,
  parameter int CTRL_REG = 13,
  parameter int DATA_REG = 14
) (
  input logic              clk,
  input logic              rstN,
  input logic              c22Valid,
  input logic              c22Write,
  input logic [REG_W-1:0]  c22Reg,
  input logic [DATA_W-1:0] c22Wdata,
  input logic [DATA_W-1:0] ctrlWord,
  input logic              mmdStrobe,
  input logic              mmdWrite,
  input logic [DATA_W-1:0] mmdRegAddr
);

  logic [1:0] fnBits;
  assign fnBits = ctrlWord[DATA_W-1 -: 2];

  a_r4_strobe_needs_data_mode: assert property (@(posedge clk) disable iff (!rstN)
    mmdStrobe |-> (c22Valid && (c22Reg == REG_W'(DATA_REG)) && (fnBits != 2'b00)));

  a_r11_write_has_strobe: assert property (@(posedge clk) disable iff (!rstN)
    mmdWrite |-> mmdStrobe);

  a_r1_ctrl_load: assert property (@(posedge clk) disable iff (!rstN)
    (c22Valid && c22Write && (c22Reg == REG_W'(CTRL_REG))) |=> (ctrlWord == $past(c22Wdata)));

  a_r4_no_inc_plain: assert property (@(posedge clk) disable iff (!rstN)
    (mmdStrobe && (fnBits == 2'b01)) |=> $stable(mmdRegAddr));

  a_r5_inc_rw: assert property (@(posedge clk) disable iff (!rstN)
    (mmdStrobe && (fnBits == 2'b10)) |=> (mmdRegAddr == $past(mmdRegAddr) + DATA_W'(1)));

  a_r6_inc_on_write: assert property (@(posedge clk) disable iff (!rstN)
    (mmdStrobe && mmdWrite && (fnBits == 2'b11)) |=> (mmdRegAddr == $past(mmdRegAddr) + DATA_W'(1)));

  a_r6_hold_on_read: assert property (@(posedge clk) disable iff (!rstN)
    (mmdStrobe && !mmdWrite && (fnBits == 2'b11)) |=> $stable(mmdRegAddr));

endmodule

bind mmd_window_bridge mmd_window_bridge_chk #(
  .DATA_W(DATA_W), .DEV_W(DEV_W), .REG_W(REG_W),
  .CTRL_REG(CTRL_REG), .DATA_REG(DATA_REG)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .c22Valid  (c22Valid),
  .c22Write  (c22Write),
  .c22Reg    (c22Reg),
  .c22Wdata  (c22Wdata),
  .ctrlWord  (ctrlWord),
  .mmdStrobe (mmdStrobe),
  .mmdWrite  (mmdWrite),
  .mmdRegAddr(mmdRegAddr)
);

// File: tb/sim_mmd_window_bridge.sv
module sim_mmd_window_bridge;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        c22Valid = 1'b0;
  logic        c22Write = 1'b0;
  logic [4:0]  c22Reg = '0;
  logic [15:0] c22Wdata = '0;
  logic [15:0] c22Rdata;
  logic        mmdStrobe;
  logic        mmdWrite;
  logic [4:0]  mmdDevad;
  logic [15:0] mmdRegAddr;
  logic [15:0] mmdWdata;
  logic [15:0] mmdRdata;

  always #5 clk = ~clk;

  // Simple MMD register content: a fixed function of device and address
  assign mmdRdata = mmdRegAddr ^ {mmdDevad, 11'h000} ^ 16'h5A3C;

  mmd_window_bridge u0 (
    .clk(clk), .rstN(rstN), .c22Valid(c22Valid), .c22Write(c22Write),
    .c22Reg(c22Reg), .c22Wdata(c22Wdata), .c22Rdata(c22Rdata),
    .mmdStrobe(mmdStrobe), .mmdWrite(mmdWrite), .mmdDevad(mmdDevad),
    .mmdRegAddr(mmdRegAddr), .mmdWdata(mmdWdata), .mmdRdata(mmdRdata)
  );

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  // Behavioural reference state
  int ctrlM;
  int addrM [32];

  task automatic chk(input int got, input int exp, input string what);
    total++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, got, exp);
    end
  endtask

  function automatic int mmdVal(input int dev, input int a);
    return (a ^ (dev << 11) ^ 16'h5A3C) & 16'hFFFF;
  endfunction

  // One management access, compared against the model in its cycle
  task automatic acc(input bit wr, input int r, input int d, input string tag);
    int fn;
    int dev;
    bit dataHit;
    @(negedge clk);
    c22Valid = 1'b1; c22Write = wr; c22Reg = 5'(r); c22Wdata = 16'(d);
    #1;
    fn  = (ctrlM >> 14) & 3;
    dev = ctrlM & 31;
    dataHit = (r == 14) && (fn != 0);
    chk(int'(mmdStrobe), int'(dataHit), {tag, " strobe"});
    chk(int'(mmdWrite), int'(dataHit && wr), {tag, " write flag"});
    chk(int'(mmdDevad), dev, {tag, " devad"});
    chk(int'(mmdRegAddr), addrM[dev], {tag, " regaddr"});
    if (dataHit && wr) chk(int'(mmdWdata), d & 16'hFFFF, {tag, " wdata"});
    if (!wr) begin
      if (r == 13) chk(int'(c22Rdata), ctrlM, {tag, " rdata ctrl"});
      else if (r == 14 && fn == 0) chk(int'(c22Rdata), addrM[dev], {tag, " rdata addr"});
      else if (r == 14) chk(int'(c22Rdata), mmdVal(dev, addrM[dev]), {tag, " rdata data"});
      else chk(int'(c22Rdata), 0, {tag, " rdata other"});
    end
    if (wr && r == 13) ctrlM = d & 16'hFFFF;
    if (r == 14) begin
      if (fn == 0 && wr) addrM[dev] = d & 16'hFFFF;
      else if (fn == 2 || (fn == 3 && wr)) addrM[dev] = (addrM[dev] + 1) & 16'hFFFF;
    end
    @(posedge clk);
    #1;
    c22Valid = 1'b0; c22Write = 1'b0;
  endtask

  initial begin
    ctrlM = 0;
    for (int i = 0; i < 32; i++) addrM[i] = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R9 reset state
    acc(0, 13, 0, "R9 reset ctrl");
    acc(0, 14, 0, "R9 reset addr dev0");
    acc(1, 13, 16'h0011, "R9 sel dev17");
    acc(0, 14, 0, "R9 reset addr dev17");

    // R1 full control readback, R2 device select
    acc(1, 13, 16'h2BE3, "R1 ctrl write");
    acc(0, 13, 0, "R1 ctrl readback");
    acc(1, 13, 16'h0003, "R2 addr mode dev3");
    // R3 address load and readback
    acc(1, 14, 16'h0014, "R3 load addr");
    acc(0, 14, 0, "R3 read addr");
    // R4 plain data access, R11 write data
    acc(1, 13, 16'h4003, "R4 data mode");
    acc(1, 14, 16'hBEEF, "R11 data write");
    acc(0, 14, 0, "R4 data read");
    acc(0, 14, 0, "R4 address held");

    // R5 increment on reads and writes
    acc(1, 13, 16'h8003, "R5 inc rw");
    acc(0, 14, 0, "R5 read 1");
    acc(0, 14, 0, "R5 read 2");
    acc(1, 14, 16'h1234, "R5 write");
    acc(0, 14, 0, "R5 read 3");

    // R6 increment only on writes
    acc(1, 13, 16'hC003, "R6 inc wr");
    acc(0, 14, 0, "R6 read hold");
    acc(0, 14, 0, "R6 read hold 2");
    acc(1, 14, 16'h0F0F, "R6 write inc");
    acc(0, 14, 0, "R6 after write");

    // R8 independence: dev 9 keeps its own address
    acc(1, 13, 16'h0009, "R8 sel dev9");
    acc(0, 14, 0, "R8 dev9 untouched");
    acc(1, 14, 16'h0700, "R8 dev9 load");
    acc(1, 13, 16'h0003, "R8 back dev3");
    acc(0, 14, 0, "R8 dev3 kept");

    // R7 wrap at 0xFFFF
    acc(1, 13, 16'h0007, "R7 sel dev7");
    acc(1, 14, 16'hFFFF, "R7 load top");
    acc(1, 13, 16'h8007, "R7 inc rw");
    acc(0, 14, 0, "R7 read at top");
    acc(0, 14, 0, "R7 read after wrap");
    acc(1, 13, 16'h0007, "R7 addr mode");
    acc(0, 14, 0, "R7 wrapped addr");

    // R10 other registers ignored
    acc(1, 13, 16'hC009, "R10 setup");
    acc(1, 0, 16'hFFFF, "R10 write reg0");
    acc(1, 15, 16'h0000, "R10 write reg15");
    acc(0, 5, 0, "R10 read reg5");
    acc(0, 13, 0, "R10 ctrl unchanged");
    acc(1, 13, 16'h0009, "R10 addr mode");
    acc(0, 14, 0, "R10 dev9 addr unchanged");

    // idle cycle: no strobe
    @(negedge clk);
    chk(int'(mmdStrobe), 0, "R4 idle no strobe");

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule